// File: doc/BRIEF.md
# ATM Cell Payload Pattern Generator

This block produces the 48 payload bytes of each outgoing ATM cell, one byte per clock, for a test-traffic transmitter. A one-cycle cell-start pulse begins a new payload. At that pulse the block latches its configuration: the payload mode, the PRBS length, the PRBS-15 inversion, the data-pattern choice, the user byte, AAL-1 enable and the CSI bit. It then streams the bytes on a byte bus with a valid flag and a last-byte flag. Header generation, HEC and scheduling belong to neighbouring blocks.

Five payload kinds are available. The first is a 32-bit departure timestamp counted in 100 ns ticks. The second is a PRBS that runs on across cell boundaries, in PRBS-9, PRBS-15 (plain or inverted) or PRBS-23. The third is a PRBS-9 that restarts with every cell. The fourth is a fixed data pattern. The fifth is an incrementing byte ramp. With AAL-1 enabled, payload byte 0 carries a sequence-number byte protected by CRC-3 and even parity, and the pattern fills the other 47 bytes. A one-shot error-add request flips a single bit in the next PRBS byte.

Top module: `cell_payload_gen`

## Requirements
- R1: While reset is asserted, and at any time no payload is in progress, `pay_valid` and `pay_last` are 0 and `pay_data` is 0x00.
- R2: A `cell_start` pulse in cycle n gives `pay_valid` high in cycles n+1 to n+48, with byte index 0 to 47 in order. `pay_last` is high only with index 47. A new `cell_start` at any time restarts at index 0.
- R3: Mode, PRBS select, inversion, pattern select, user byte, AAL-1 enable and CSI are sampled only on `cell_start`. Changing them during a payload has no effect on that payload.
- R4: Cross-cell PRBS (`mode`=1) runs the taps x^9+x^5+1 (`prbs_len`=0), x^15+x^14+1 (1) or x^23+x^18+1 (2 or 3). These taps act on one 23-bit shift register that is set to all ones by reset. Each step shifts left, and the feedback bit (state bit N-1 XOR bit T-1) enters bit 0 and is also the output bit. A byte is eight steps, with the first bit in bit 7. The register advances only on PRBS bytes and carries over between cells.
- R5: In `mode`=1 with `prbs_len`=1 and `prbs_inv`=1, every PRBS byte is complemented.
- R6: Single-cell PRBS (`mode`=2) always uses the PRBS-9 taps and reloads the register to all ones at every cell start. Identical cells therefore produce identical bytes.
- R7: A 32-bit counter increments on each `ts_tick`. In `mode`=0 the counter value before the cell-start edge is placed in the first four pattern bytes, most significant byte first. The remaining bytes equal their payload index.
- R8: `mode`=3 sends `user_byte` when `pat_sel`=0. When `pat_sel`=1 it sends 0xAA at even and 0x55 at odd payload indices. When `pat_sel` is 2 or 3 it sends 0xFF at even and 0x00 at odd indices.
- R9: `mode`=4 to 7 sends bytes equal to their payload index, each one greater than the byte before.
- R10: With `aal1_en`, byte 0 holds, from bit 7 down: CSI, a 3-bit count, the CRC-3 (x^3+x+1) of {CSI,count}, and even parity over the whole byte. The count is 0 for the first such cell after reset and rises by one, modulo 8, per AAL-1 cell. No PRBS step is spent on byte 0.
- R11: An `err_add` pulse flips bit 0 of the next PRBS byte output after the pulse cycle, and only that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_start | input | 1 | Begins a new payload |
| mode | input | 3 | 0 timestamp, 1 cross-cell PRBS, 2 single-cell PRBS, 3 data pattern, 4-7 incrementing |
| prbs_len | input | 2 | 0 PRBS-9, 1 PRBS-15, 2/3 PRBS-23 |
| prbs_inv | input | 1 | Complement PRBS-15 output |
| pat_sel | input | 2 | 0 user byte, 1 AA/55, 2/3 FF/00 |
| user_byte | input | 8 | Fixed pattern byte |
| aal1_en | input | 1 | Insert AAL-1 sequence byte at index 0 |
| csi | input | 1 | CSI bit for the AAL-1 byte |
| ts_tick | input | 1 | 100 ns timestamp tick |
| err_add | input | 1 | Request one PRBS bit error |
| pay_data | output | 8 | Payload byte |
| pay_valid | output | 1 | Byte is valid |
| pay_last | output | 1 | Last payload byte |

## Verification
The bench builds the block with the default 48-byte payload. A run of about a dozen AAL-1 cells therefore wraps the 3-bit count. A few cross-cell PRBS-9 cells pass the 511-bit period of that sequence, so continuity across boundaries and wrap-around are both exercised. The same length puts the first four timestamp bytes and the ramp that follows inside one cell, including the shift by one byte under AAL-1. Restarts in mid-payload and back-to-back pulses on the last byte test the framing edges.

// File: rtl/cell_payload_gen.sv
module cell_payload_gen #(
  parameter int PAYLOAD_BYTES = 48
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cell_start,
  input  logic [2:0] mode,
  input  logic [1:0] prbs_len,
  input  logic       prbs_inv,
  input  logic [1:0] pat_sel,
  input  logic [7:0] user_byte,
  input  logic       aal1_en,
  input  logic       csi,
  input  logic       ts_tick,
  input  logic       err_add,
  output logic [7:0] pay_data,
  output logic       pay_valid,
  output logic       pay_last
);
  localparam int IW = $clog2(PAYLOAD_BYTES);
  localparam logic [IW-1:0] LAST = IW'(PAYLOAD_BYTES - 1);

  logic          active;
  logic [IW-1:0] idx;
  logic [2:0]    c_mode;
  logic [1:0]    c_len, c_pat;
  logic          c_inv, c_aal, c_csi;
  logic [7:0]    c_user;
  logic [22:0]   lfsr;
  logic [31:0]   ts_cnt, ts_cap;
  logic [2:0]    sc_next, c_sc;
  logic          err_pend;

  function automatic logic [30:0] prbs8(input logic [22:0] s, input logic [1:0] len);
    logic [22:0] t;
    logic [7:0]  b;
    logic        fb;
    t = s;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      case (len)
        2'd0:    fb = t[8] ^ t[4];
        2'd1:    fb = t[14] ^ t[13];
        default: fb = t[22] ^ t[17];
      endcase
      b = {b[6:0], fb};
      t = {t[21:0], fb};
    end
    return {b, t};
  endfunction

  function automatic logic [2:0] crc3(input logic [3:0] d);
    logic [6:0] r;
    r = {d, 3'b000};
    for (int i = 6; i >= 3; i--)
      if (r[i]) r[i-:4] = r[i-:4] ^ 4'b1011;
    return r[2:0];
  endfunction

  wire         is_prbs = (c_mode == 3'd1) || (c_mode == 3'd2);
  wire         hdr     = c_aal && (idx == '0);
  wire         consume = active && is_prbs && !hdr;
  wire [1:0]   eff_len = (c_mode == 3'd2) ? 2'd0 : c_len;
  wire [30:0]  step    = prbs8(lfsr, eff_len);
  wire         inv15   = (c_mode == 3'd1) && (c_len == 2'd1) && c_inv;
  wire [IW-1:0] pos    = idx - IW'(c_aal);
  wire [6:0]   hdr7    = {c_csi, c_sc, crc3({c_csi, c_sc})};
  wire [7:0]   aal_byte = {hdr7, ^hdr7};

  logic [7:0] pat_byte, ts_byte;
  always_comb begin
    case (pos[1:0])
      2'd0:    ts_byte = ts_cap[31:24];
      2'd1:    ts_byte = ts_cap[23:16];
      2'd2:    ts_byte = ts_cap[15:8];
      default: ts_byte = ts_cap[7:0];
    endcase
    case (c_mode)
      3'd0:       pat_byte = (pos < IW'(4)) ? ts_byte : 8'(idx);
      3'd1, 3'd2: pat_byte = step[30:23] ^ {8{inv15}} ^ {7'b0, err_pend};
      3'd3: begin
        case (c_pat)
          2'd0:    pat_byte = c_user;
          2'd1:    pat_byte = idx[0] ? 8'h55 : 8'hAA;
          default: pat_byte = idx[0] ? 8'h00 : 8'hFF;
        endcase
      end
      default:    pat_byte = 8'(idx);
    endcase
  end

  assign pay_valid = active;
  assign pay_last  = active && (idx == LAST);
  assign pay_data  = !active ? 8'h00 : hdr ? aal_byte : pat_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      idx      <= '0;
      c_mode   <= '0;
      c_len    <= '0;
      c_pat    <= '0;
      c_inv    <= 1'b0;
      c_aal    <= 1'b0;
      c_csi    <= 1'b0;
      c_user   <= '0;
      lfsr     <= '1;
      ts_cnt   <= '0;
      ts_cap   <= '0;
      sc_next  <= '0;
      c_sc     <= '0;
      err_pend <= 1'b0;
    end else begin
      if (ts_tick) ts_cnt <= ts_cnt + 32'd1;
      err_pend <= (err_pend && !consume) || err_add;
      if (consume) lfsr <= step[22:0];
      if (cell_start) begin
        active <= 1'b1;
        idx    <= '0;
        c_mode <= mode;
        c_len  <= prbs_len;
        c_pat  <= pat_sel;
        c_inv  <= prbs_inv;
        c_aal  <= aal1_en;
        c_csi  <= csi;
        c_user <= user_byte;
        ts_cap <= ts_cnt;
        if (aal1_en) begin
          c_sc    <= sc_next;
          sc_next <= sc_next + 3'd1;
        end
        if (mode == 3'd2) lfsr <= '1;
      end else if (active) begin
        if (idx == LAST) active <= 1'b0;
        else             idx    <= idx + IW'(1);
      end
    end
  end

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cell_start |=> pay_valid && !pay_last);
  p_cell_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pay_last && !cell_start |=> !pay_valid);
  p_aal_parity_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pay_valid && c_aal && idx == '0 |-> (^pay_data) == 1'b0);
  p_sc_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cell_start && aal1_en |=> c_sc == $past(sc_next));
  p_err_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    consume && err_pend && !err_add |=> !err_pend);
endmodule

// File: tb/tb_cell_payload_gen.sv
module tb_cell_payload_gen;
  localparam int NB = 48;

  logic       clk = 0, rst_n = 0, cell_start = 0;
  logic [2:0] mode = 0;
  logic [1:0] prbs_len = 0, pat_sel = 0;
  logic       prbs_inv = 0, aal1_en = 0, csi = 0, ts_tick = 0, err_add = 0;
  logic [7:0] user_byte = 0;
  logic [7:0] pay_data;
  logic       pay_valid, pay_last;

  always #2 clk = ~clk;

  cell_payload_gen #(.PAYLOAD_BYTES(NB)) dut (
    .clk(clk), .rst_n(rst_n), .cell_start(cell_start), .mode(mode),
    .prbs_len(prbs_len), .prbs_inv(prbs_inv), .pat_sel(pat_sel),
    .user_byte(user_byte), .aal1_en(aal1_en), .csi(csi), .ts_tick(ts_tick),
    .err_add(err_add), .pay_data(pay_data), .pay_valid(pay_valid),
    .pay_last(pay_last));

  int tests = 0, fails = 0, tick_n = 0;
  bit done = 0;

  int m_act, m_idx, m_mode, m_len, m_inv, m_aal, m_csi, m_pat, m_user, m_csc, m_snext;
  int unsigned m_ts, m_tscap;
  int m_lfsr;
  bit m_err;

  function automatic int prbs_byte(input int s, input int len, output int ns);
    int n, t, b, fb;
    n = (len == 0) ? 9 : (len == 1) ? 15 : 23;
    t = (len == 0) ? 5 : (len == 1) ? 14 : 18;
    b = 0;
    for (int i = 0; i < 8; i++) begin
      fb = ((s >> (n - 1)) ^ (s >> (t - 1))) & 1;
      b = ((b << 1) | fb) & 255;
      s = ((s << 1) | fb) & 32'h7FFFFF;
    end
    ns = s;
    return b;
  endfunction

  function automatic int aal_hdr(input int c, input int sc);
    int v, r, h;
    v = c * 8 + sc;
    r = v << 3;
    for (int i = 6; i >= 3; i--)
      if ((r >> i) & 1) r = r ^ (11 << (i - 3));
    h = v * 8 + (r & 7);
    return h * 2 + ($countones(h) & 1);
  endfunction

  function automatic int cur_len();
    if (m_mode == 2) return 0;
    return (m_len >= 2) ? 2 : m_len;
  endfunction

  function automatic int exp_byte();
    int pos, ns, b;
    if (m_aal != 0 && m_idx == 0) return aal_hdr(m_csi, m_csc);
    pos = m_idx - m_aal;
    case (m_mode)
      0: return (pos < 4) ? int'((m_tscap >> (8 * (3 - pos))) & 255) : m_idx;
      1, 2: begin
        b = prbs_byte(m_lfsr, cur_len(), ns);
        if (m_mode == 1 && m_len == 1 && m_inv != 0) b = b ^ 255;
        if (m_err) b = b ^ 1;
        return b;
      end
      3: begin
        if (m_pat == 0) return m_user;
        if (m_pat == 1) return (m_idx % 2 == 0) ? 8'hAA : 8'h55;
        return (m_idx % 2 == 0) ? 8'hFF : 8'h00;
      end
      default: return m_idx;
    endcase
  endfunction

  function automatic string tag();
    if (m_aal != 0 && m_idx == 0) return "R10";
    if ((m_mode == 1 || m_mode == 2) && m_err) return "R11";
    case (m_mode)
      0: return "R7";
      1: return (m_len == 1 && m_inv != 0) ? "R5" : "R4";
      2: return "R6";
      3: return "R8";
      default: return "R9";
    endcase
  endfunction

  always @(posedge clk) begin
    bit cons;
    int ns;
    int unsigned ts_old;
    if (!rst_n) begin
      m_act = 0; m_idx = 0; m_mode = 0; m_len = 0; m_inv = 0; m_aal = 0;
      m_csi = 0; m_pat = 0; m_user = 0; m_csc = 0; m_snext = 0;
      m_ts = 0; m_tscap = 0; m_lfsr = 32'h7FFFFF; m_err = 0;
    end else begin
      ts_old = m_ts;
      if (ts_tick) m_ts = m_ts + 1;
      cons = (m_act != 0) && (m_mode == 1 || m_mode == 2) && !(m_aal != 0 && m_idx == 0);
      if (cons) begin
        void'(prbs_byte(m_lfsr, cur_len(), ns));
        m_lfsr = ns;
      end
      m_err = (m_err && !cons) || err_add;
      if (cell_start) begin
        m_act = 1; m_idx = 0;
        m_mode = mode; m_len = prbs_len; m_inv = prbs_inv; m_aal = aal1_en;
        m_csi = csi; m_pat = pat_sel; m_user = user_byte; m_tscap = ts_old;
        if (aal1_en) begin m_csc = m_snext; m_snext = (m_snext + 1) % 8; end
        if (mode == 3'd2) m_lfsr = 32'h7FFFFF;
      end else if (m_act != 0) begin
        if (m_idx == NB - 1) m_act = 0; else m_idx++;
      end
    end
  end

  task automatic chk(input int act, input int exp, input string req);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        chk(pay_valid, 0, "R1");
        chk(pay_data, 0, "R1");
      end else begin
        chk(pay_valid, (m_act != 0) ? 1 : 0, "R2");
        chk(pay_last, (m_act != 0 && m_idx == NB - 1) ? 1 : 0, "R2");
        if (m_act != 0) chk(pay_data, exp_byte(), tag());
        else chk(pay_data, 0, "R1");
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin
      @(negedge clk);
      ts_tick = (tick_n % 3 == 0);
      tick_n++;
    end
  endtask

  task automatic start_cell(input int md, input int ln, input int iv, input int aal,
                            input int c, input int pt, input int ub);
    cyc(1);
    mode = md[2:0]; prbs_len = ln[1:0]; prbs_inv = iv[0]; aal1_en = aal[0];
    csi = c[0]; pat_sel = pt[1:0]; user_byte = ub[7:0]; cell_start = 1;
    cyc(1);
    cell_start = 0;
  endtask

  initial begin
    cyc(4);
    rst_n = 1;
    cyc(3);
    start_cell(4, 0, 0, 0, 0, 0, 0); cyc(50);                 // R9
    start_cell(3, 0, 0, 0, 0, 0, 8'h3C); cyc(48);             // R8 user
    start_cell(3, 0, 0, 0, 0, 1, 0); cyc(48);                 // R8 AA/55
    start_cell(3, 0, 0, 0, 0, 2, 0); cyc(48);                 // R8 FF/00
    cyc(20);
    start_cell(0, 0, 0, 0, 0, 0, 0); cyc(48);                 // R7
    for (int k = 0; k < 12; k++) begin                        // R4 PRBS-9 past period
      start_cell(1, 0, 0, 0, 0, 0, 0); cyc(46);
    end
    cyc(3);
    start_cell(1, 1, 0, 0, 0, 0, 0); cyc(46);                 // R4 PRBS-15
    start_cell(1, 1, 1, 0, 0, 0, 0); cyc(46);                 // R5
    start_cell(1, 2, 0, 0, 0, 0, 0); cyc(46);                 // R4 PRBS-23
    start_cell(1, 3, 0, 0, 0, 0, 0); cyc(48);
    start_cell(2, 2, 0, 0, 0, 0, 0); cyc(48);                 // R6
    start_cell(2, 1, 1, 0, 0, 0, 0); cyc(48);                 // R6 again
    for (int k = 0; k < 10; k++) begin                        // R10 count wrap
      start_cell((k % 2 == 0) ? 4 : 1, 1, 0, 1, k % 3 == 0 ? 1 : 0, 0, 0);
      cyc(47);
    end
    start_cell(0, 0, 0, 1, 1, 0, 0); cyc(48);                 // R7 with R10
    start_cell(1, 2, 0, 0, 0, 0, 0); cyc(5);                  // R11
    err_add = 1; cyc(1); err_add = 0; cyc(10);
    err_add = 1; cyc(2); err_add = 0; cyc(40);
    start_cell(1, 0, 0, 1, 0, 0, 0);                          // R11 on header byte
    err_add = 1; cyc(1); err_add = 0; cyc(48);
    start_cell(4, 0, 0, 0, 0, 0, 0);                          // R3
    mode = 3'd1; prbs_len = 2'd2; aal1_en = 1; pat_sel = 2'd1; user_byte = 8'h99;
    cyc(48);
    start_cell(3, 0, 0, 0, 0, 0, 8'h5A); cyc(10);             // R2 restart
    start_cell(2, 0, 0, 0, 0, 0, 0); cyc(20);
    start_cell(4, 0, 0, 1, 1, 0, 0); cyc(55);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule